// File: doc/BRIEF.md
# Six-Phase Packet Fetch and Dispatch Front End

This block is the instruction front end of a wide-issue core. It produces a program address for each 256-bit fetch packet and sends it to instruction memory. It waits for that memory to deliver the packet. The packet then moves through a dispatch phase, which tags each of its eight 32-bit words with the functional-unit class that must execute it. A decode phase follows, which turns those tags into a lane map. The packet reaches execute (E1) as a registered output. There are six stages in order: address generate, address send, memory wait, packet read, dispatch, decode. Execute takes the decode stage's output.

When the pipeline is full and memory answers in time, one packet leaves for execute on every clock. The extra fetch phases add latency but do not reduce this rate.

A stall happens when memory is not ready for the packet in the wait phase. The wait, send and generate phases then freeze, while the read, dispatch and decode phases keep draining toward execute.

A branch redirect arrives from execute. It replaces the address that is being generated. Every packet already past generation still executes, so a branch taken from a full pipeline is followed by five delay-slot packets.

Top module: `pkt_fetch_pipe`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `e1_valid` and `mem_req` are 0. After any reset, fetching starts again at `RESET_ADDR`.
- R2: With memory always ready, the first packet after reset is presented with `e1_valid` high after the 7th rising edge following the release of reset. Its `e1_pc` equals `RESET_ADDR`.
- R3: Without a redirect, each packet presented at execute has an address exactly 32 bytes above the previous one.
- R4: A packet whose data memory accepts (`mem_ready` high while it waits) is presented at execute after exactly the third rising edge following that acceptance edge. In every other cycle `e1_valid` is 0. With `mem_ready` held high, packets therefore reach execute back to back.
- R5: While a fetched packet waits and `mem_ready` is low, `mem_req` is 0 and no new packet enters the read phase. Packets already in the read, dispatch and decode phases keep advancing to execute.
- R6: `br_valid` asserted in a cycle with the six stages full causes the following to be presented at execute: exactly five further packets at sequential addresses, then the packet at `br_target`, then sequential packets from there. This holds even if the same cycle starts a memory stall.
- R7: `e1_slots` carries the memory word unchanged: slot s is bits [32s+31:32s].
- R8: `e1_lane` bit u*8+s is 1 exactly when bits [3:2] of slot s equal u. The unit codes are 0 multiply, 1 arithmetic/logic, 2 load/store, 3 control. Each slot sets exactly one bit.
- R9: `e1_pc` is the address that was sent to memory for the packet in `e1_slots`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch redirect from execute |
| br_target | input | 32 | Redirect address, 32-byte aligned |
| mem_req | output | 1 | Fetch request for `mem_addr` this cycle |
| mem_addr | output | 32 | Packet address being sent |
| mem_rdata | input | 256 | Packet for the oldest outstanding request |
| mem_ready | input | 1 | `mem_rdata` is valid this cycle |
| e1_valid | output | 1 | A packet is presented to execute |
| e1_pc | output | 32 | Address of the presented packet |
| e1_slots | output | 256 | Eight 32-bit instruction words |
| e1_lane | output | 32 | Unit-by-slot lane map, bit u*8+s |

## Verification
Each packet is due at execute a fixed number of edges after a known event. The first packet after reset is due on edge 7. Any later packet is due three edges after the edge on which memory accepted it. A redirected stream switches to the target after exactly five packets.

The bench carries its own memory model. It records each accepted packet together with its due edge, then samples the outputs half a cycle after every edge. In each cycle it either matches the head of that queue or requires `e1_valid` to be low.

It checks the address order against a separate stream model that counts delay-slot packets, not cycles. Stalls can therefore stretch a branch shadow without breaking the check.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Functional-unit classes; the value is the lane index in the E1 map.
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = $clog2(NUM_UNITS);

  typedef enum logic [UNIT_W-1:0] {
    UNIT_MUL  = 2'd0,
    UNIT_ALU  = 2'd1,
    UNIT_DATA = 2'd2,
    UNIT_CTRL = 2'd3
  } unit_e;
endpackage

// File: rtl/pf_front.sv
// Address generate and address send phases.
module pf_front #(
  parameter int              ADDR_W     = 32,
  parameter int              PKT_W      = 256,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  output logic              ps_valid,
  output logic [ADDR_W-1:0] ps_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PKT_W / 8);

  logic              pg_valid;
  logic [ADDR_W-1:0] pg_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_valid <= 1'b0;
      pg_pc    <= RESET_ADDR;
      ps_valid <= 1'b0;
      ps_pc    <= RESET_ADDR;
    end else if (hold) begin
      // Send phase frozen; a redirect replaces only the generated address.
      if (br_valid) begin
        pg_valid <= 1'b1;
        pg_pc    <= br_target;
      end
    end else if (br_valid) begin
      // Generate mux picks the target; the old generated address is dropped.
      ps_valid <= 1'b1;
      ps_pc    <= br_target;
      pg_valid <= 1'b1;
      pg_pc    <= br_target + STEP;
    end else begin
      ps_valid <= pg_valid;
      ps_pc    <= pg_pc;
      pg_valid <= 1'b1;
      if (pg_valid) pg_pc <= pg_pc + STEP;
    end
  end

  p_front_hold_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(ps_pc) && $stable(ps_valid)));
endmodule

// File: rtl/pf_wait.sv
// Memory wait and packet read phases.
module pf_wait #(
  parameter int ADDR_W = 32,
  parameter int PKT_W  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps_valid,
  input  logic [ADDR_W-1:0] ps_pc,
  input  logic              mem_ready,
  input  logic [PKT_W-1:0]  mem_rdata,
  output logic              stall,
  output logic              pr_valid,
  output logic [ADDR_W-1:0] pr_pc,
  output logic [PKT_W-1:0]  pr_pkt
);
  logic              pw_valid;
  logic [ADDR_W-1:0] pw_pc;
  logic              take;

  assign stall = pw_valid && !mem_ready;
  assign take  = pw_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_valid <= 1'b0;
      pr_valid <= 1'b0;
    end else begin
      if (!stall) pw_valid <= ps_valid;
      pr_valid <= take;
    end
  end

  // Data registers carry no reset.
  always_ff @(posedge clk) begin
    if (!stall) pw_pc <= ps_pc;
    if (take) begin
      pr_pc  <= pw_pc;
      pr_pkt <= mem_rdata;
    end
  end

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pw_valid && $stable(pw_pc)));
  p_read_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> !pr_valid);
endmodule

// File: rtl/pf_dispatch.sv
// Dispatch phase: tag every slot with its unit class.
module pf_dispatch #(
  parameter int ADDR_W   = 32,
  parameter int SLOTS    = 8,
  parameter int WORD_W   = 32,
  parameter int UNIT_LSB = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pr_valid,
  input  logic [ADDR_W-1:0]             pr_pc,
  input  logic [SLOTS*WORD_W-1:0]       pr_pkt,
  output logic                          dp_valid,
  output logic [ADDR_W-1:0]             dp_pc,
  output logic [SLOTS*WORD_W-1:0]       dp_pkt,
  output logic [SLOTS*pf_pkg::UNIT_W-1:0] dp_tag
);
  localparam int UW = pf_pkg::UNIT_W;

  logic [SLOTS*UW-1:0] tag_n;

  for (genvar s = 0; s < SLOTS; s++) begin : g_tag
    assign tag_n[s*UW +: UW] = pr_pkt[s*WORD_W + UNIT_LSB +: UW];
  end

  always_ff @(posedge clk) begin
    if (rst) dp_valid <= 1'b0;
    else     dp_valid <= pr_valid;
  end

  always_ff @(posedge clk) begin
    dp_pc  <= pr_pc;
    dp_pkt <= pr_pkt;
    dp_tag <= tag_n;
  end
endmodule

// File: rtl/pf_decode.sv
// Decode phase and the registered E1 interface.
module pf_decode #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              dp_valid,
  input  logic [ADDR_W-1:0]                 dp_pc,
  input  logic [SLOTS*WORD_W-1:0]           dp_pkt,
  input  logic [SLOTS*pf_pkg::UNIT_W-1:0]   dp_tag,
  output logic                              e1_valid,
  output logic [ADDR_W-1:0]                 e1_pc,
  output logic [SLOTS*WORD_W-1:0]           e1_slots,
  output logic [pf_pkg::NUM_UNITS*SLOTS-1:0] e1_lane
);
  localparam int UW = pf_pkg::UNIT_W;
  localparam int NU = pf_pkg::NUM_UNITS;

  logic                    dc_valid;
  logic [ADDR_W-1:0]       dc_pc;
  logic [SLOTS*WORD_W-1:0] dc_pkt;
  logic [NU*SLOTS-1:0]     dc_lane, lane_n;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign lane_n[u*SLOTS+s] = (dp_tag[s*UW +: UW] == UW'(u));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dc_valid <= 1'b0;
      e1_valid <= 1'b0;
    end else begin
      dc_valid <= dp_valid;
      e1_valid <= dc_valid;
    end
  end

  always_ff @(posedge clk) begin
    dc_pc    <= dp_pc;
    dc_pkt   <= dp_pkt;
    dc_lane  <= lane_n;
    e1_pc    <= dc_pc;
    e1_slots <= dc_pkt;
    e1_lane  <= dc_lane;
  end

  p_e1_drain_r4: assert property (@(posedge clk) disable iff (rst)
    dc_valid |=> e1_valid);

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    logic [NU-1:0] col;
    for (genvar u = 0; u < NU; u++) begin : g_col
      assign col[u] = e1_lane[u*SLOTS+s];
    end
    p_lane_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      e1_valid |-> ($countones(col) == 1));
  end
endmodule

// File: rtl/pkt_fetch_pipe.sv
module pkt_fetch_pipe #(
  parameter int                ADDR_W     = 32,
  parameter int                SLOTS      = 8,
  parameter int                WORD_W     = 32,
  parameter int                UNIT_LSB   = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              br_valid,
  input  logic [ADDR_W-1:0]                 br_target,
  output logic                              mem_req,
  output logic [ADDR_W-1:0]                 mem_addr,
  input  logic [SLOTS*WORD_W-1:0]           mem_rdata,
  input  logic                              mem_ready,
  output logic                              e1_valid,
  output logic [ADDR_W-1:0]                 e1_pc,
  output logic [SLOTS*WORD_W-1:0]           e1_slots,
  output logic [pf_pkg::NUM_UNITS*SLOTS-1:0] e1_lane
);
  localparam int PKT_W = SLOTS * WORD_W;
  localparam int UW    = pf_pkg::UNIT_W;

  logic              stall;
  logic              ps_valid, pr_valid, dp_valid;
  logic [ADDR_W-1:0] ps_pc, pr_pc, dp_pc;
  logic [PKT_W-1:0]  pr_pkt, dp_pkt;
  logic [SLOTS*UW-1:0] dp_tag;

  pf_front #(.ADDR_W(ADDR_W), .PKT_W(PKT_W), .RESET_ADDR(RESET_ADDR)) u_front (
    .clk(clk), .rst(rst), .hold(stall),
    .br_valid(br_valid), .br_target(br_target),
    .ps_valid(ps_valid), .ps_pc(ps_pc)
  );

  // The send phase drives memory only while the wait phase can accept.
  assign mem_req  = ps_valid && !stall;
  assign mem_addr = ps_pc;

  pf_wait #(.ADDR_W(ADDR_W), .PKT_W(PKT_W)) u_wait (
    .clk(clk), .rst(rst), .ps_valid(ps_valid), .ps_pc(ps_pc),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .stall(stall),
    .pr_valid(pr_valid), .pr_pc(pr_pc), .pr_pkt(pr_pkt)
  );

  pf_dispatch #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .WORD_W(WORD_W), .UNIT_LSB(UNIT_LSB)) u_disp (
    .clk(clk), .rst(rst), .pr_valid(pr_valid), .pr_pc(pr_pc), .pr_pkt(pr_pkt),
    .dp_valid(dp_valid), .dp_pc(dp_pc), .dp_pkt(dp_pkt), .dp_tag(dp_tag)
  );

  pf_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst(rst), .dp_valid(dp_valid), .dp_pc(dp_pc), .dp_pkt(dp_pkt),
    .dp_tag(dp_tag), .e1_valid(e1_valid), .e1_pc(e1_pc),
    .e1_slots(e1_slots), .e1_lane(e1_lane)
  );
endmodule

// File: tb/pkt_fetch_pipe_tb_top.sv
`timescale 1ns/1ps
module pkt_fetch_pipe_tb_top;
  localparam int          AW   = 32;
  localparam int          SL   = 8;
  localparam int          PW   = 256;
  localparam int          NU   = 4;
  localparam logic [31:0] STEP = 32'd32;
  localparam logic [31:0] RST_ADDR = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_rdata = '0;
  logic          mem_ready = 1'b1;
  logic          e1_valid;
  logic [AW-1:0] e1_pc;
  logic [PW-1:0] e1_slots;
  logic [NU*SL-1:0] e1_lane;

  always #2.5 clk = ~clk;

  pkt_fetch_pipe dut_i (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_target(br_target),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .e1_valid(e1_valid), .e1_pc(e1_pc),
    .e1_slots(e1_slots), .e1_lane(e1_lane)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pkt_of(input logic [31:0] a);
    logic [PW-1:0] p;
    for (int s = 0; s < SL; s++)
      p[s*32 +: 32] = (a * 32'h9E37_79B1) ^ (32'(s) * 32'h85EB_CA6B) ^ (a >> 3);
    return p;
  endfunction

  function automatic logic [NU*SL-1:0] lanes_of(input logic [PW-1:0] p);
    logic [NU*SL-1:0] l;
    for (int u = 0; u < NU; u++)
      for (int s = 0; s < SL; s++)
        l[u*SL+s] = (p[s*32+2 +: 2] == 2'(u));
    return l;
  endfunction

  // Edge counter
  int cyc = 0;
  int base = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural memory and expectation model
  typedef struct { int t; logic [31:0] pc; } due_t;
  due_t dq[$];
  bit          pending, prev_ret, prev_req, first_seen;
  logic [31:0] pend_addr, prev_addr, exp_next, tgt_saved;
  int          delay_left;

  task automatic model_clear();
    dq.delete();
    pending = 0; prev_ret = 0; prev_req = 0; first_seen = 0;
    pend_addr = '0; prev_addr = '0;
    exp_next = RST_ADDR; delay_left = 0; tgt_saved = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; br_valid = 1'b0; mem_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(e1_valid == 1'b0, "R1", "e1_valid in reset", PW'(e1_valid), '0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", PW'(mem_req), '0);
    model_clear();
    rst = 1'b0;
    base = cyc;
    #1;
    chk(e1_valid == 1'b0, "R1", "e1_valid after release", PW'(e1_valid), '0);
    chk(mem_req == 1'b0, "R1", "mem_req after release", PW'(mem_req), '0);
  endtask

  task automatic step(input bit rdy, input bit br, input logic [31:0] tgt);
    int k;
    @(negedge clk);
    k = cyc - base;
    // Outputs produced by edge k
    if (dq.size() > 0 && dq[0].t == k) begin
      chk(e1_valid == 1'b1, "R4", "packet due at E1", PW'(e1_valid), PW'(1));
      chk(e1_pc == dq[0].pc, "R9", "e1_pc vs sent addr", PW'(e1_pc), PW'(dq[0].pc));
      chk(e1_slots == pkt_of(dq[0].pc), "R7", "slot words", e1_slots, pkt_of(dq[0].pc));
      chk(e1_lane == lanes_of(pkt_of(dq[0].pc)), "R8", "lane map",
          PW'(e1_lane), PW'(lanes_of(pkt_of(dq[0].pc))));
      if (!first_seen) begin
        chk(k == 7, "R2", "first packet edge", PW'(k), PW'(7));
        chk(e1_pc == RST_ADDR, "R2", "first packet pc", PW'(e1_pc), PW'(RST_ADDR));
        first_seen = 1;
      end
      if (delay_left > 0) begin
        chk(e1_pc == exp_next, "R6", "branch stream order", PW'(e1_pc), PW'(exp_next));
        delay_left--;
        exp_next = (delay_left == 0) ? tgt_saved : exp_next + STEP;
      end else begin
        chk(e1_pc == exp_next, "R3", "sequential order", PW'(e1_pc), PW'(exp_next));
        exp_next = exp_next + STEP;
      end
      void'(dq.pop_front());
    end else begin
      chk(e1_valid == 1'b0, "R4", "no packet due", PW'(e1_valid), '0);
    end
    // Memory effects of edge k
    if (prev_ret) begin
      dq.push_back('{t: k + 3, pc: pend_addr});
      pending = 0;
    end
    if (prev_req) begin
      pend_addr = prev_addr;
      pending = 1;
    end
    // Drive the next cycle
    mem_ready = rdy;
    br_valid  = br;
    br_target = tgt;
    mem_rdata = pkt_of(pend_addr);
    if (br) begin
      delay_left = 5;
      tgt_saved = tgt;
    end
    #1;
    prev_ret  = pending && rdy;
    prev_req  = mem_req;
    prev_addr = mem_addr;
    if (pending && !rdy)
      chk(mem_req == 1'b0, "R5", "no request while stalled", PW'(mem_req), '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000.0 * 5.0);
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    model_clear();
    do_reset();
    // R2/R3/R4: startup and steady stream
    repeat (14) step(1'b1, 1'b0, '0);
    // R5: stall patterns
    repeat (3) step(1'b0, 1'b0, '0);
    repeat (2) step(1'b1, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    repeat (10) step(1'b1, 1'b0, '0);
    // R6: branch from a full, stall-free pipeline
    step(1'b1, 1'b1, 32'h0000_4000);
    repeat (12) step(1'b1, 1'b0, '0);
    // R6: branch in the first cycle of a stall
    step(1'b0, 1'b1, 32'h0000_8000);
    repeat (2) step(1'b0, 1'b0, '0);
    repeat (14) step(1'b1, 1'b0, '0);
    // R4/R5: irregular readiness
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[1:0] != 2'b00, 1'b0, '0);
    end
    repeat (10) step(1'b1, 1'b0, '0);
    // R1/R2: reset in mid-run restarts at the reset address
    do_reset();
    repeat (14) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 32'h0000_2000);
    repeat (12) step(1'b1, 1'b0, '0);
    finish_run();
  end
endmodule